// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data Unit

This block is the arithmetic core of a 16-bit fixed-point signal processor. It keeps four 16-bit operand registers and two 40-bit accumulators. Each accumulator is built from a low word, a middle word and an 8-bit guard extension. In one clock the unit can multiply two operand registers, with the product either replacing an accumulator or added into it. In the same single clock it can instead add or subtract a 32-bit operand pair, round an accumulator to its middle word, or apply a 16-bit bitwise operation to the middle word alone. There is no pipeline, so the operation in the next cycle already sees each result.

Operands are signed fractions by default. A 16x16 product is sign-extended to 40 bits and doubled, which puts the binary point at accumulator bit 31. The multiply operations can take unsigned operands instead. A single register port loads and reads every operand register and every accumulator part. A five-bit flag vector reports the outcome of the last operation.

Top module: `mac_data_unit`

## Requirements
- R1: After the asynchronous reset, every operand register, both accumulators and all flags read as zero.
- R2: The register port maps addresses 0..3 to operand words X0, X1, Y0 and Y1. Addresses 4, 5 and 6 select the low, middle and extension parts of accumulator A, and 7, 8 and 9 select the same parts of B. A write changes only the addressed part. A read of an extension returns it sign-extended to 16 bits.
- R3: Op code 1 (multiply) loads the accumulator chosen by `acc_sel_i` (0 = A, 1 = B) with twice the signed product of the operand words chosen by `src_a_i` and `src_b_i`, sign-extended to 40 bits.
- R4: Op code 2 (multiply-accumulate) adds that product to the full 40-bit accumulator. Back-to-back operations chain without a stall cycle.
- R5: When `unsigned_i` is 1, multiply and multiply-accumulate treat both operands as unsigned (zero-extended). Add and subtract ignore `unsigned_i`.
- R6: Op codes 3 (add) and 4 (subtract) add the 32-bit pair {X1,X0} to the accumulator, or subtract it from the accumulator. `src_a_i[1]` = 1 selects {Y1,Y0} instead. The pair is sign-extended to 40 bits first.
- R7: Op code 5 (round) with `round_mode_i` = 1 adds 0x8000 to the accumulator and then clears the low word (round half up).
- R8: With `round_mode_i` = 0, rounding is convergent. When the low word is exactly 0x8000, the result is whichever neighbour has bit 16 clear.
- R9: Op codes 6, 7 and 8 (AND, OR, XOR) combine the middle word with the operand word chosen by `src_a_i`. The extension and low word are left unchanged. These ops set N and Z from the 16-bit result, clear V, and keep C and E.
- R10: `flags_o` = {E,N,Z,V,C}. After ops 1..5, N is bit 39 of the result and Z means the result is zero. E is set unless bits 39..31 are all equal.
- R11: After add, multiply-accumulate and round, V flags signed 40-bit overflow and C is the carry out of bit 39. After subtract, C is the borrow. A multiply clears V and C.
- R12: A port write in the same cycle as an operation is handled as follows. If it targets the destination accumulator, it is lost to the operation result. If it targets an operand register, the operation uses the old value and the new value is stored. If it targets the other accumulator, it is applied.
- R13: An operation never alters the accumulator that `acc_sel_i` does not select. Op codes 0 and 9..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Execute `op_i` this cycle |
| op_i | input | 4 | Operation code |
| acc_sel_i | input | 1 | Destination accumulator, 0 = A, 1 = B |
| src_a_i | input | 2 | First operand word (0 X0, 1 X1, 2 Y0, 3 Y1); bit 1 selects the pair |
| src_b_i | input | 2 | Second multiplier operand word |
| unsigned_i | input | 1 | Unsigned multiply operands |
| round_mode_i | input | 1 | 0 convergent, 1 round half up |
| reg_we_i | input | 1 | Register port write enable |
| reg_addr_i | input | 4 | Register port address |
| reg_wdata_i | input | 16 | Register port write data |
| reg_rdata_o | output | 16 | Register port read data (combinational) |
| flags_o | output | 5 | {E,N,Z,V,C} |

## Verification
An operation and a register-port write can both fall in one clock. The bench provokes this by raising `reg_we_i` in the cycle that `op_valid_i` is high. The write goes in turn to an operand register the operation reads, to the destination accumulator, and to the other accumulator. Each outcome is judged by reading back the accumulators and the operand register after the edge. The expected values are computed arithmetically for the old operand and for the priority stated in R12.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int unsigned REG_AW = 4;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_MPY = 4'd1,
    OP_MAC = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_RND = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_EOR = 4'd8
  } mac_op_e;

  localparam logic [REG_AW-1:0] RA_X0    = 4'd0;
  localparam logic [REG_AW-1:0] RA_X1    = 4'd1;
  localparam logic [REG_AW-1:0] RA_Y0    = 4'd2;
  localparam logic [REG_AW-1:0] RA_Y1    = 4'd3;
  localparam logic [REG_AW-1:0] RA_A_LO  = 4'd4;
  localparam logic [REG_AW-1:0] RA_A_MID = 4'd5;
  localparam logic [REG_AW-1:0] RA_A_EXT = 4'd6;
  localparam logic [REG_AW-1:0] RA_B_LO  = 4'd7;
  localparam logic [REG_AW-1:0] RA_B_MID = 4'd8;
  localparam logic [REG_AW-1:0] RA_B_EXT = 4'd9;

  typedef struct packed {
    logic e;
    logic n;
    logic z;
    logic v;
    logic c;
  } mac_flags_t;

endpackage

// File: rtl/mac_input_regs.sv
module mac_input_regs
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [1:0]        sel_a_i,
  input  logic [1:0]        sel_b_i,
  input  logic              pair_y_i,
  output logic [DW-1:0]     opa_o,
  output logic [DW-1:0]     opb_o,
  output logic [2*DW-1:0]   pair_o,
  output logic [DW-1:0]     rd_o
);

  localparam int unsigned NREG = 4;

  logic [DW-1:0] r [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_in
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && addr_i == REG_AW'(g))      q <= wdata_i;
    end
    assign r[g] = q;
  end

  assign opa_o  = r[sel_a_i];
  assign opb_o  = r[sel_b_i];
  // index 1/0 form X, 3/2 form Y
  assign pair_o = pair_y_i ? {r[3], r[2]} : {r[1], r[0]};
  assign rd_o   = r[addr_i[1:0]];

endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int unsigned DW = 16,
  parameter int unsigned EW = 8
) (
  input  logic [DW-1:0]      a_i,
  input  logic [DW-1:0]      b_i,
  input  logic               uns_i,
  output logic [EW+2*DW-1:0] prod_o
);

  localparam int unsigned PW = 2 * DW;
  localparam int unsigned AW = EW + PW;

  logic [PW-1:0] a_x, b_x, p_raw;
  logic [AW-1:0] p_ext;

  // extend operands to full product width; low PW bits of the product are exact
  assign a_x   = uns_i ? {{DW{1'b0}}, a_i} : {{DW{a_i[DW-1]}}, a_i};
  assign b_x   = uns_i ? {{DW{1'b0}}, b_i} : {{DW{b_i[DW-1]}}, b_i};
  assign p_raw = a_x * b_x;
  assign p_ext = uns_i ? {{EW{1'b0}}, p_raw} : {{EW{p_raw[PW-1]}}, p_raw};
  // fractional alignment: binary point at bit PW-1
  assign prod_o = {p_ext[AW-2:0], 1'b0};

endmodule

// File: rtl/mac_acc_alu.sv
module mac_acc_alu
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned EW = 8
) (
  input  logic [3:0]         op_i,
  input  logic [EW+2*DW-1:0] acc_i,
  input  logic [EW+2*DW-1:0] prod_i,
  input  logic [2*DW-1:0]    pair_i,
  input  logic [DW-1:0]      lsrc_i,
  input  logic               conv_i,
  input  mac_flags_t         flags_i,
  output logic [EW+2*DW-1:0] res_o,
  output mac_flags_t         flags_o,
  output logic               act_o
);

  localparam int unsigned AW = EW + 2 * DW;
  localparam int unsigned UW = EW + 1;
  localparam logic [AW-1:0] HALF = {{(AW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};

  logic [AW-1:0] pair_ext, addend, b_op;
  logic [AW:0]   sum;
  logic          sub, carry, ovf;
  logic [DW-1:0] msp, lres;
  logic [UW-1:0] upper;

  assign pair_ext = {{EW{pair_i[2*DW-1]}}, pair_i};
  assign msp      = acc_i[2*DW-1:DW];

  always_comb begin
    sub    = 1'b0;
    addend = '0;
    unique case (op_i)
      OP_MAC:  addend = prod_i;
      OP_ADD:  addend = pair_ext;
      OP_SUB:  begin addend = pair_ext; sub = 1'b1; end
      OP_RND:  addend = HALF;
      default: addend = '0;
    endcase
  end

  assign b_op  = sub ? ~addend : addend;
  assign sum   = {1'b0, acc_i} + {1'b0, b_op} + {{AW{1'b0}}, sub};
  assign carry = sub ? ~sum[AW] : sum[AW];
  assign ovf   = (acc_i[AW-1] == b_op[AW-1]) && (sum[AW-1] != acc_i[AW-1]);

  always_comb begin
    lres = msp;
    unique case (op_i)
      OP_AND:  lres = msp & lsrc_i;
      OP_OR:   lres = msp | lsrc_i;
      OP_EOR:  lres = msp ^ lsrc_i;
      default: lres = msp;
    endcase
  end

  always_comb begin
    res_o = acc_i;
    act_o = 1'b1;
    unique case (op_i)
      OP_MPY: res_o = prod_i;
      OP_MAC, OP_ADD, OP_SUB: res_o = sum[AW-1:0];
      OP_RND: begin
        res_o = {sum[AW-1:DW], {DW{1'b0}}};
        if (conv_i && acc_i[DW-1:0] == HALF[DW-1:0]) res_o[DW] = 1'b0;
      end
      OP_AND, OP_OR, OP_EOR: res_o = {acc_i[AW-1:2*DW], lres, acc_i[DW-1:0]};
      default: act_o = 1'b0;
    endcase
  end

  assign upper = res_o[AW-1:AW-UW];

  always_comb begin
    flags_o = flags_i;
    unique case (op_i)
      OP_MPY, OP_MAC, OP_ADD, OP_SUB, OP_RND: begin
        flags_o.e = !((&upper) || (~|upper));
        flags_o.n = res_o[AW-1];
        flags_o.z = (res_o == '0);
        flags_o.v = (op_i == OP_MPY) ? 1'b0 : ovf;
        flags_o.c = (op_i == OP_MPY) ? 1'b0 : carry;
      end
      OP_AND, OP_OR, OP_EOR: begin
        flags_o.n = lres[DW-1];
        flags_o.z = (lres == '0);
        flags_o.v = 1'b0;
      end
      default: flags_o = flags_i;
    endcase
  end

endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
  parameter int unsigned DW = 16,
  parameter int unsigned EW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [EW+2*DW-1:0] load_val_i,
  input  logic               wr_i,
  input  logic [1:0]         part_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [EW+2*DW-1:0] q_o
);

  localparam int unsigned AW = EW + 2 * DW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= load_val_i;  // operation result beats a port write
    end else if (wr_i) begin
      unique case (part_i)
        2'd0:    q_o[DW-1:0]    <= wdata_i;
        2'd1:    q_o[2*DW-1:DW] <= wdata_i;
        2'd2:    q_o[AW-1:2*DW] <= wdata_i[EW-1:0];
        default: q_o <= q_o;
      endcase
    end
  end

endmodule

// File: rtl/mac_data_unit.sv
module mac_data_unit
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned EW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic              acc_sel_i,
  input  logic [1:0]        src_a_i,
  input  logic [1:0]        src_b_i,
  input  logic              unsigned_i,
  input  logic              round_mode_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [4:0]        flags_o
);

  localparam int unsigned AW    = EW + 2 * DW;
  localparam int unsigned NACC  = 2;
  localparam int unsigned NPART = 3;

  logic [DW-1:0]   opa, opb, in_rd;
  logic [2*DW-1:0] pair;
  logic [AW-1:0]   prod, acc_cur, res;
  logic [AW-1:0]   acc_q [NACC];
  logic [AW-1:0]   acc_a, acc_b;
  logic            act, fire;
  mac_flags_t      flags_q, flags_nxt;

  mac_input_regs #(.DW(DW)) i_in_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .sel_a_i  (src_a_i),
    .sel_b_i  (src_b_i),
    .pair_y_i (src_a_i[1]),
    .opa_o    (opa),
    .opb_o    (opb),
    .pair_o   (pair),
    .rd_o     (in_rd)
  );

  mac_multiplier #(.DW(DW), .EW(EW)) i_mult (
    .a_i    (opa),
    .b_i    (opb),
    .uns_i  (unsigned_i),
    .prod_o (prod)
  );

  assign acc_cur = acc_q[acc_sel_i];

  mac_acc_alu #(.DW(DW), .EW(EW)) i_alu (
    .op_i    (op_i),
    .acc_i   (acc_cur),
    .prod_i  (prod),
    .pair_i  (pair),
    .lsrc_i  (opa),
    .conv_i  (!round_mode_i),
    .flags_i (flags_q),
    .res_o   (res),
    .flags_o (flags_nxt),
    .act_o   (act)
  );

  assign fire = op_valid_i && act;

  for (genvar k = 0; k < NACC; k++) begin : g_acc
    localparam logic [REG_AW-1:0] BASE = REG_AW'(RA_A_LO + NPART * k);
    localparam logic [REG_AW-1:0] LAST = REG_AW'(RA_A_LO + NPART * k + NPART - 1);
    logic          hit, load;
    logic [1:0]    part;
    logic [AW-1:0] q;

    assign hit  = reg_we_i && (reg_addr_i >= BASE) && (reg_addr_i <= LAST);
    assign part = 2'(reg_addr_i - BASE);
    assign load = fire && (acc_sel_i == 1'(k));

    mac_acc_reg #(.DW(DW), .EW(EW)) i_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (res),
      .wr_i       (hit),
      .part_i     (part),
      .wdata_i    (reg_wdata_i),
      .q_o        (q)
    );
    assign acc_q[k] = q;
  end

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (fire) flags_q <= flags_nxt;
  end

  assign flags_o = flags_q;

  always_comb begin
    unique case (reg_addr_i)
      RA_X0, RA_X1, RA_Y0, RA_Y1: reg_rdata_o = in_rd;
      RA_A_LO:  reg_rdata_o = acc_a[DW-1:0];
      RA_A_MID: reg_rdata_o = acc_a[2*DW-1:DW];
      RA_A_EXT: reg_rdata_o = {{(DW-EW){acc_a[AW-1]}}, acc_a[AW-1:2*DW]};
      RA_B_LO:  reg_rdata_o = acc_b[DW-1:0];
      RA_B_MID: reg_rdata_o = acc_b[2*DW-1:DW];
      RA_B_EXT: reg_rdata_o = {{(DW-EW){acc_b[AW-1]}}, acc_b[AW-1:2*DW]};
      default:  reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/mac_data_unit_checker.sv
module mac_data_unit_checker
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned EW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_valid_i,
  input logic [3:0]         op_i,
  input logic               acc_sel_i,
  input logic               reg_we_i,
  input logic [REG_AW-1:0]  reg_addr_i,
  input logic [EW+2*DW-1:0] acc_a_i,
  input logic [EW+2*DW-1:0] acc_b_i,
  input logic [4:0]         flags_i
);

  localparam int unsigned AW = EW + 2 * DW;

  logic arith, logic_op, any_op, port_a, port_b;
  assign arith    = op_valid_i && (op_i >= OP_MPY) && (op_i <= OP_RND);
  assign logic_op = op_valid_i && (op_i >= OP_AND) && (op_i <= OP_EOR);
  assign any_op   = arith || logic_op;
  assign port_a   = reg_we_i && (reg_addr_i >= RA_A_LO) && (reg_addr_i <= RA_A_EXT);
  assign port_b   = reg_we_i && (reg_addr_i >= RA_B_LO) && (reg_addr_i <= RA_B_EXT);

  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (acc_a_i == '0 && acc_b_i == '0 && flags_i == '0));

  assert_round_lsp_clear_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_RND && !acc_sel_i) |=> acc_a_i[DW-1:0] == '0);

  assert_round_lsp_clear_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_RND && acc_sel_i) |=> acc_b_i[DW-1:0] == '0);

  assert_logic_keeps_parts_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logic_op && !acc_sel_i) |=>
      (acc_a_i[AW-1:2*DW] == $past(acc_a_i[AW-1:2*DW]) &&
       acc_a_i[DW-1:0] == $past(acc_a_i[DW-1:0])));

  assert_logic_keeps_parts_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logic_op && acc_sel_i) |=>
      (acc_b_i[AW-1:2*DW] == $past(acc_b_i[AW-1:2*DW]) &&
       acc_b_i[DW-1:0] == $past(acc_b_i[DW-1:0])));

  assert_ext_flag_a_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith && !acc_sel_i) |=>
      flags_i[4] == !((&acc_a_i[AW-1:2*DW-1]) || (~|acc_a_i[AW-1:2*DW-1])));

  assert_ext_flag_b_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith && acc_sel_i) |=>
      flags_i[4] == !((&acc_b_i[AW-1:2*DW-1]) || (~|acc_b_i[AW-1:2*DW-1])));

  assert_other_acc_stable_b_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_op && !acc_sel_i && !port_b) |=> $stable(acc_b_i));

  assert_other_acc_stable_a_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_op && acc_sel_i && !port_a) |=> $stable(acc_a_i));

endmodule

bind mac_data_unit mac_data_unit_checker #(.DW(DW), .EW(EW)) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .acc_sel_i  (acc_sel_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .acc_a_i    (acc_a),
  .acc_b_i    (acc_b),
  .flags_i    (flags_o)
);

// File: tb/test_mac_data_unit.sv
module test_mac_data_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        acc_sel = 1'b0;
  logic [1:0]  src_a = '0, src_b = '0;
  logic        uns = 1'b0, rmode = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [4:0]  flags;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] vals [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_data_unit i_mac_data_unit (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .op_i(op),
    .acc_sel_i(acc_sel), .src_a_i(src_a), .src_b_i(src_b),
    .unsigned_i(uns), .round_mode_i(rmode), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .flags_o(flags)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_acc(input bit sel, output logic [39:0] v);
    logic [15:0] lo, mid, ext;
    logic [3:0] b;
    b = sel ? 4'd7 : 4'd4;
    rd(b, lo); rd(b + 4'd1, mid); rd(b + 4'd2, ext);
    v = {ext[7:0], mid, lo};
  endtask

  task automatic set_acc(input bit sel, input logic [39:0] v);
    logic [3:0] b;
    b = sel ? 4'd7 : 4'd4;
    wr(b, v[15:0]); wr(b + 4'd1, v[31:16]); wr(b + 4'd2, {8'h00, v[39:32]});
  endtask

  task automatic do_op(input logic [3:0] o, input bit sel, input logic [1:0] sa = 2'd0,
                       input logic [1:0] sb = 2'd0, input bit u = 1'b0, input bit rm = 1'b0,
                       input bit we = 1'b0, input logic [3:0] wa = 4'd0,
                       input logic [15:0] wd = 16'd0);
    @(negedge clk);
    op_valid = 1'b1; op = o; acc_sel = sel; src_a = sa; src_b = sb; uns = u; rmode = rm;
    reg_we = we; reg_addr = wa; reg_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0; reg_we = 1'b0;
  endtask

  function automatic logic [39:0] fprod(input logic [15:0] a, input logic [15:0] b, input bit u);
    longint p;
    if (u) p = longint'({48'd0, a}) * longint'({48'd0, b});
    else   p = longint'($signed(a)) * longint'($signed(b));
    return 40'(p * 2);
  endfunction

  task automatic add_ref(input logic [39:0] a, input logic [39:0] b, input bit sub,
                         output logic [39:0] r, output bit v, output bit c);
    longint sa, sb, ua, ub, s;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({24'd0, a}); ub = longint'({24'd0, b});
    s = sub ? sa - sb : sa + sb;
    v = (s > 64'sh7F_FFFF_FFFF) || (s < -64'sh80_0000_0000);
    c = sub ? (ua < ub) : ((ua + ub) >= 64'sh100_0000_0000);
    r = 40'(s);
  endtask

  function automatic logic [4:0] fl(input logic [39:0] r, input bit v, input bit c);
    logic e;
    e = !((&r[39:31]) || (~|r[39:31]));
    return {e, r[39], r == 40'd0, v, c};
  endfunction

  initial begin
    logic [15:0] d;
    logic [39:0] got, exp, prev, bsave, asave;
    bit v, c;

    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h4000; vals[6] = 16'hC000; vals[7] = 16'h1234;

    #(2*CLK_PERIOD + 2);
    rst_ni = 1'b1;

    // R1: reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 reset addr %0d", a), 64'(d), 64'd0);
    end
    chk("R1 reset flags", 64'(flags), 64'd0);

    // R2: register port map, part writes, extension sign extension
    wr(4'd0, 16'h1111); wr(4'd1, 16'h2222); wr(4'd2, 16'h3333); wr(4'd3, 16'h4444);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a), d);
      chk($sformatf("R2 operand addr %0d", a), 64'(d), 64'({4{4'(a + 1)}}));
    end
    wr(4'd6, 16'h0080);
    rd(4'd6, d); chk("R2 ext sign extend", 64'(d), 64'hFF80);
    rd_acc(1'b0, got); chk("R2 part write A", 64'(got), 64'h80_0000_0000);
    wr(4'd8, 16'hABCD);
    rd_acc(1'b1, got); chk("R2 part write B mid", 64'(got), 64'h00_ABCD_0000);
    rd_acc(1'b0, got); chk("R2 B write leaves A", 64'(got), 64'h80_0000_0000);

    // R3/R10/R13: signed multiply sweep into A, B held
    bsave = 40'h00_ABCD_0000;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        wr(4'd0, vals[i]); wr(4'd2, vals[j]);
        do_op(4'd1, 1'b0, 2'd0, 2'd2);
        exp = fprod(vals[i], vals[j], 1'b0);
        rd_acc(1'b0, got);
        chk($sformatf("R3 mpy %h*%h", vals[i], vals[j]), 64'(got), 64'(exp));
        chk($sformatf("R10 mpy flags %h*%h", vals[i], vals[j]), 64'(flags), 64'(fl(exp, 1'b0, 1'b0)));
      end
    end
    rd_acc(1'b1, got); chk("R13 B untouched by A ops", 64'(got), 64'(bsave));
    rd_acc(1'b0, asave);

    // R5: unsigned multiply sweep into B
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        wr(4'd1, vals[i]); wr(4'd3, vals[j]);
        do_op(4'd1, 1'b1, 2'd1, 2'd3, 1'b1);
        exp = fprod(vals[i], vals[j], 1'b1);
        rd_acc(1'b1, got);
        chk($sformatf("R5 umpy %h*%h", vals[i], vals[j]), 64'(got), 64'(exp));
      end
    end
    rd_acc(1'b0, got); chk("R13 A untouched by B ops", 64'(got), 64'(asave));

    // R4/R11: chained signed MAC sweep
    set_acc(1'b0, 40'h00_4000_0000);
    prev = 40'h00_4000_0000;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        wr(4'd0, vals[i]); wr(4'd2, vals[j]);
        do_op(4'd2, 1'b0, 2'd0, 2'd2);
        add_ref(prev, fprod(vals[i], vals[j], 1'b0), 1'b0, exp, v, c);
        rd_acc(1'b0, got);
        chk($sformatf("R4 mac %h*%h", vals[i], vals[j]), 64'(got), 64'(exp));
        chk($sformatf("R11 mac flags %h*%h", vals[i], vals[j]), 64'(flags), 64'(fl(exp, v, c)));
        prev = exp;
      end
    end

    // R4: back-to-back MAC without stall
    wr(4'd1, 16'h4000); wr(4'd3, 16'h2000);
    set_acc(1'b0, 40'd0);
    @(negedge clk);
    op_valid = 1'b1; op = 4'd2; acc_sel = 1'b0; src_a = 2'd1; src_b = 2'd3; uns = 1'b0;
    repeat (4) @(negedge clk);
    op_valid = 1'b0;
    rd_acc(1'b0, got);
    chk("R4 four back-to-back macs", 64'(got), 64'(40'(4) * fprod(16'h4000, 16'h2000, 1'b0)));

    // R6/R11: add and subtract of pairs
    begin
      logic [39:0] acc_v [6];
      logic [31:0] pair_v [6];
      bit          is_sub [6];
      bit          use_y  [6];
      acc_v[0] = 40'h00_1000_0000; pair_v[0] = 32'h2000_0001; is_sub[0] = 0; use_y[0] = 0;
      acc_v[1] = 40'h7F_FFFF_FFFF; pair_v[1] = 32'h0000_0001; is_sub[1] = 0; use_y[1] = 1;
      acc_v[2] = 40'h00_0000_0000; pair_v[2] = 32'h0000_0001; is_sub[2] = 1; use_y[2] = 1;
      acc_v[3] = 40'hFF_FFFF_FFFF; pair_v[3] = 32'h0000_0001; is_sub[3] = 0; use_y[3] = 0;
      acc_v[4] = 40'h80_0000_0000; pair_v[4] = 32'h0000_0001; is_sub[4] = 1; use_y[4] = 0;
      acc_v[5] = 40'h00_1234_5678; pair_v[5] = 32'h8000_0000; is_sub[5] = 0; use_y[5] = 1;
      for (int k = 0; k < 6; k++) begin
        set_acc(1'b1, acc_v[k]);
        if (use_y[k]) begin wr(4'd3, pair_v[k][31:16]); wr(4'd2, pair_v[k][15:0]); end
        else          begin wr(4'd1, pair_v[k][31:16]); wr(4'd0, pair_v[k][15:0]); end
        // unsigned_i set on odd cases: must not affect add/sub (R5)
        do_op(is_sub[k] ? 4'd4 : 4'd3, 1'b1, use_y[k] ? 2'd2 : 2'd0, 2'd0, 1'(k % 2));
        add_ref(acc_v[k], {{8{pair_v[k][31]}}, pair_v[k]}, is_sub[k], exp, v, c);
        rd_acc(1'b1, got);
        chk($sformatf("R6 addsub case %0d", k), 64'(got), 64'(exp));
        chk($sformatf("R11 addsub flags case %0d", k), 64'(flags), 64'(fl(exp, v, c)));
      end
    end

    // R7/R8: rounding in both modes
    begin
      logic [39:0] rv [6];
      logic [39:0] lower, upper;
      logic [15:0] frac;
      rv[0] = 40'h00_1234_7FFF; rv[1] = 40'h00_1234_8000; rv[2] = 40'h00_1235_8000;
      rv[3] = 40'h00_1234_8001; rv[4] = 40'h00_7FFF_8000; rv[5] = 40'hFF_FFFF_8000;
      for (int k = 0; k < 6; k++) begin
        for (int m = 0; m < 2; m++) begin
          set_acc(1'b0, rv[k]);
          do_op(4'd5, 1'b0, 2'd0, 2'd0, 1'b0, 1'(m));
          frac  = rv[k][15:0];
          lower = {rv[k][39:16], 16'h0000};
          upper = lower + 40'h1_0000;
          if (frac < 16'h8000)      exp = lower;
          else if (frac > 16'h8000) exp = upper;
          else if (m == 1)          exp = upper;
          else                      exp = lower[16] ? upper : lower;
          add_ref(rv[k], 40'h8000, 1'b0, prev, v, c);
          rd_acc(1'b0, got);
          chk($sformatf("%s round case %0d", m ? "R7" : "R8", k), 64'(got), 64'(exp));
          chk($sformatf("R10 round flags case %0d mode %0d", k, m), 64'(flags), 64'(fl(exp, v, c)));
        end
      end
    end

    // R9: logic ops on the middle word only
    begin
      logic [15:0] src_v [4];
      logic [3:0]  lop [4];
      logic [15:0] mres;
      src_v[0] = 16'h0FF0; lop[0] = 4'd6;
      src_v[1] = 16'h0FF0; lop[1] = 4'd7;
      src_v[2] = 16'h0FF0; lop[2] = 4'd8;
      src_v[3] = 16'h0000; lop[3] = 4'd6;
      for (int k = 0; k < 4; k++) begin
        set_acc(1'b0, 40'h5A_F0F0_1234);
        wr(4'd2, src_v[k]);
        do_op(lop[k], 1'b0, 2'd2);
        case (lop[k])
          4'd6:    mres = 16'hF0F0 & src_v[k];
          4'd7:    mres = 16'hF0F0 | src_v[k];
          default: mres = 16'hF0F0 ^ src_v[k];
        endcase
        rd_acc(1'b0, got);
        chk($sformatf("R9 logic case %0d", k), 64'(got), 64'({8'h5A, mres, 16'h1234}));
        chk($sformatf("R9 logic flags case %0d", k), 64'(flags[3:1]),
            64'({mres[15], mres == 16'h0, 1'b0}));
      end
    end

    // R12: same-cycle op and port write
    wr(4'd0, 16'h4000); wr(4'd2, 16'h4000);
    do_op(4'd1, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 4'd0, 16'h2000);
    rd_acc(1'b0, got); chk("R12 op uses old operand", 64'(got), 64'(fprod(16'h4000, 16'h4000, 1'b0)));
    rd(4'd0, d);       chk("R12 operand write stored", 64'(d), 64'h2000);
    do_op(4'd1, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 4'd5, 16'hBEEF);
    rd_acc(1'b0, got); chk("R12 op beats write to dest", 64'(got), 64'(fprod(16'h2000, 16'h4000, 1'b0)));
    set_acc(1'b1, 40'd0);
    do_op(4'd1, 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 4'd8, 16'h1357);
    rd_acc(1'b1, got); chk("R12 write to other acc applied", 64'(got), 64'h00_1357_0000);
    rd_acc(1'b0, got); chk("R12 op result with other write", 64'(got), 64'(fprod(16'h4000, 16'h4000, 1'b0)));

    // R13: undefined op codes change nothing
    rd_acc(1'b0, asave);
    d = {11'd0, flags};
    do_op(4'd0, 1'b0, 2'd0, 2'd2);
    do_op(4'd12, 1'b0, 2'd0, 2'd2);
    rd_acc(1'b0, got); chk("R13 nop/undefined keep acc", 64'(got), 64'(asave));
    chk("R13 nop/undefined keep flags", 64'(flags), 64'(d[4:0]));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule